// File: doc/BRIEF.md
# Time-Multiplexed Cascadable FIR Filter Core

This block is a finite impulse response filter for 16-bit signed samples and 16-bit signed coefficients. It produces a 32-bit result. A small array of multiplier lanes is reused for 1, 2, 4 or 8 clock cycles per sample, so the number of taps grows with the clock-to-sample ratio. Each sample period, every lane multiplies one tap of the delay line by one coefficient. The partial products are summed into an accumulator. On the last cycle of the period, the sum plus a 32-bit expansion input is registered onto the result bus. The core also gives out a sample-rate strobe that can serve as a clock enable for the logic that feeds it.

Several cores can be chained. A delayed copy of the input stream leaves the core on a cascade bus, and that bus feeds the next core's sample input. The previous core's result enters on the expansion input. The core at the end of a chain, or one that stands alone, ignores that input. Coefficients live in an external memory that is already loaded. The core drives a word address made of a bank bit and the phase, and reads one coefficient per lane back. A swap input picks one of two banks for each sample.

Framing is set by a filter-enable input. A synchronous clear aborts the computation in progress and raises a busy flag. The stream has to be started again afterwards with a new rising edge of filter-enable.

Top module: `fir_tdm_core`

## Requirements
- R1: `ratio_sel` values 0, 1, 2 and 3 set the period to R = 1, 2, 4 or 8 clocks per sample, and the tap count to T = LANES·R. While running, `samp_tick` is high exactly in the last cycle of each period, once every R cycles.
- R2: With `busy` low and the core idle, the first rising clock edge at which `fen` is high after being low captures `din` as the first sample. At every period-ending edge with `fen` high, the next `din` is captured. If `fen` is low at a period-ending edge, that sample's result is still produced and the core then goes idle.
- R3: The result is `res` = Σ_{k<T} c_k·x[n−k] + expansion, in 32-bit two's complement with wrap-around. `res` and a one-cycle `res_vld` update at the edge that ends the period of sample x[n].
- R4: `clr_n` low at a clock edge clears the accumulator and stops the core. No result is produced for the interrupted sample. `busy` is high for the CLR_LEN (default 4) cycles after that edge.
- R5: After a clear, holding `fen` high does not restart the core. A rising edge of `fen` while `busy` is low is needed.
- R6: `swap` is sampled at each capture edge. That value picks the bank for the whole sample (0 = lower bank, 1 = upper bank). Changes of `swap` between capture edges have no effect.
- R7: After sample x[n] is captured, `dout` shows x[n−T], the sample that leaves this core's taps. The delay line starts at zero.
- R8: When `chain_end` is 1, `xin` is treated as zero.
- R9: `res_drive` = NOT(`oe_n` as registered at the previous edge). It is 0 after reset. An external pad uses it as the output enable of the result bus.
- R10: After reset, `res`, `res_vld`, `busy`, `samp_tick`, `dout` and `res_drive` are all 0.
- R11: Coefficient c_k is read from word address {bank, k / LANES}, in lane k mod LANES, at bits [16·(k mod LANES) +: 16] of `coef_data`. `coef_addr[3]` is the bank and `coef_addr[2:0]` is the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_sel | input | 2 | Clock-to-sample ratio select, 2^ratio_sel |
| fen | input | 1 | Filter enable, frames the sample stream |
| clr_n | input | 1 | Synchronous active-low accumulator clear |
| swap | input | 1 | Coefficient bank select |
| din | input | 16 | Sample input |
| dout | output | 16 | Delayed sample for the next core in a chain |
| xin | input | 32 | Expansion input from the previous core |
| chain_end | input | 1 | 1 = standalone or terminating core, xin ignored |
| coef_addr | output | 4 | Coefficient memory word address {bank, phase} |
| coef_data | input | LANES·16 | Coefficient word, one per lane |
| oe_n | input | 1 | Active-low result output enable |
| res | output | 32 | Filter result |
| res_drive | output | 1 | Registered drive enable for the result pad |
| res_vld | output | 1 | One-cycle strobe, new result |
| samp_tick | output | 1 | Sample-rate clock-enable strobe |
| busy | output | 1 | Clear in progress |

## Verification
A wrong phase count shows in the first result: the sum either takes in extra taps or misses some, so `res` differs from the computed value as soon as one period has passed. A wrong delay-line shift or a wrong `dout` tap index shows at `dout` one cycle after the next capture. Bank and swap errors show in the next result, because the two banks hold very different coefficients. A clear that does not stop the core, or that ends `busy` at the wrong time, shows within CLR_LEN+1 cycles as a stray `res_vld`, `samp_tick` or wrong `busy` level.

// File: rtl/fir_tdm_pkg.sv
package fir_tdm_pkg;
  localparam int PH_W      = 3;
  localparam int MAX_RATIO = 1 << PH_W;

  typedef logic [1:0] ratio_sel_t;

  // Index of the final MAC cycle of a sample period for a given ratio code.
  function automatic logic [PH_W-1:0] last_phase(input ratio_sel_t s);
    return PH_W'((32'd1 << s) - 32'd1);
  endfunction
endpackage

// File: rtl/fir_tdm_seq.sv
module fir_tdm_seq
  import fir_tdm_pkg::*;
#(
  parameter int CLR_LEN = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ratio_sel_t          ratio_sel,
  input  logic                fen,
  input  logic                clr_n,
  input  logic                swap,
  output logic                run,
  output logic [PH_W-1:0]     ph,
  output logic                take,
  output logic                last,
  output logic                busy,
  output logic                bank
);
  localparam int CNT_W = (CLR_LEN > 1) ? $clog2(CLR_LEN) : 1;

  logic              run_q, run_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic              fen_q;
  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              bank_q, bank_d;
  logic              start;

  always_comb begin
    last   = run_q && (ph_q == last_phase(ratio_sel));
    start  = fen && !fen_q && !busy_q && !run_q;
    take   = clr_n && (start || (last && fen));
    run_d  = run_q;
    ph_d   = ph_q;
    busy_d = busy_q;
    cnt_d  = cnt_q;
    bank_d = bank_q;
    if (!clr_n) begin
      run_d  = 1'b0;
      ph_d   = '0;
      busy_d = 1'b1;
      cnt_d  = CNT_W'(CLR_LEN - 1);
    end else begin
      if (busy_q) begin
        if (cnt_q == '0) busy_d = 1'b0;
        else             cnt_d  = cnt_q - 1'b1;
      end
      if (start) begin
        run_d = 1'b1;
        ph_d  = '0;
      end else if (last) begin
        ph_d  = '0;
        run_d = fen;
      end else if (run_q) begin
        ph_d  = ph_q + 1'b1;
      end
    end
    if (take) bank_d = swap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ph_q   <= '0;
      fen_q  <= 1'b0;
      busy_q <= 1'b0;
      cnt_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      ph_q   <= ph_d;
      fen_q  <= fen;
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      bank_q <= bank_d;
    end
  end

  assign run  = run_q;
  assign ph   = ph_q;
  assign busy = busy_q;
  assign bank = bank_q;

  AST_CLEAR_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (busy && !run)); // R4
  AST_PHASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (ph <= last_phase(ratio_sel))); // R1
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> !$past(busy)); // R5
endmodule

// File: rtl/fir_tdm_delay.sv
module fir_tdm_delay
  import fir_tdm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  take,
  input  logic [DW-1:0]         din,
  input  ratio_sel_t            ratio_sel,
  input  logic [PH_W-1:0]       ph,
  output logic [LANES*DW-1:0]   taps,
  output logic [DW-1:0]         dout
);
  localparam int DEPTH = LANES * MAX_RATIO + 1;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DW-1:0]    dl [DEPTH];
  logic [IDX_W-1:0] out_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) dl[i] <= '0;
    end else if (take) begin
      dl[0] <= din;
      for (int i = 1; i < DEPTH; i++) dl[i] <= dl[i-1];
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane_tap
    logic [IDX_W-1:0] idx;
    always_comb idx = IDX_W'(ph) * IDX_W'(LANES) + IDX_W'(l);
    assign taps[l*DW +: DW] = dl[idx];
  end

  always_comb out_idx = IDX_W'(LANES) << ratio_sel;
  assign dout = dl[out_idx];

  AST_CAPTURE_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (dl[0] == $past(din))); // R2
endmodule

// File: rtl/fir_tdm_mac.sv
module fir_tdm_mac
  import fir_tdm_pkg::*;
#(
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int AW    = 32,
  parameter int LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic                  last,
  input  logic                  clr_n,
  input  logic [PH_W-1:0]       ph,
  input  logic [LANES*DW-1:0]   taps,
  input  logic [LANES*CW-1:0]   coefs,
  input  logic [AW-1:0]         xin,
  input  logic                  chain_end,
  output logic [AW-1:0]         res,
  output logic                  vld
);
  logic signed [DW+CW-1:0] prod [LANES];
  logic signed [AW-1:0]    lane_sum;
  logic [AW-1:0]           sum;
  logic [AW-1:0]           acc_q, acc_d;
  logic [AW-1:0]           res_q, res_d;
  logic                    vld_q, vld_d;

  for (genvar l = 0; l < LANES; l++) begin : g_mul
    assign prod[l] = $signed(taps[l*DW +: DW]) * $signed(coefs[l*CW +: CW]);
  end

  always_comb begin
    lane_sum = '0;
    for (int l = 0; l < LANES; l++) lane_sum = lane_sum + AW'(prod[l]);
    sum   = ((ph == '0) ? '0 : acc_q) + lane_sum;
    acc_d = acc_q;
    res_d = res_q;
    vld_d = 1'b0;
    if (!clr_n) begin
      acc_d = '0;
    end else if (last) begin
      res_d = sum + (chain_end ? '0 : xin);
      acc_d = '0;
      vld_d = 1'b1;
    end else if (run) begin
      acc_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
      vld_q <= vld_d;
    end
  end

  assign res = res_q;
  assign vld = vld_q;

  AST_RESULT_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (last && clr_n) |=> vld); // R3
  AST_VALID_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> ($past(last) && $past(clr_n))); // R4
endmodule

// File: rtl/fir_tdm_core.sv
module fir_tdm_core
  import fir_tdm_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CW      = 16,
  parameter int AW      = 32,
  parameter int LANES   = 2,
  parameter int CLR_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            ratio_sel,
  input  logic                  fen,
  input  logic                  clr_n,
  input  logic                  swap,
  input  logic [DW-1:0]         din,
  output logic [DW-1:0]         dout,
  input  logic [AW-1:0]         xin,
  input  logic                  chain_end,
  output logic [PH_W:0]         coef_addr,
  input  logic [LANES*CW-1:0]   coef_data,
  input  logic                  oe_n,
  output logic [AW-1:0]         res,
  output logic                  res_drive,
  output logic                  res_vld,
  output logic                  samp_tick,
  output logic                  busy
);
  logic            run, take, last, bank;
  logic [PH_W-1:0] ph;
  logic [LANES*DW-1:0] taps;
  logic            oe_q;

  fir_tdm_seq #(.CLR_LEN(CLR_LEN)) u_seq (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .fen(fen), .clr_n(clr_n),
    .swap(swap), .run(run), .ph(ph), .take(take), .last(last), .busy(busy),
    .bank(bank)
  );

  fir_tdm_delay #(.DW(DW), .LANES(LANES)) u_dly (
    .clk(clk), .rst_n(rst_n), .take(take), .din(din), .ratio_sel(ratio_sel),
    .ph(ph), .taps(taps), .dout(dout)
  );

  fir_tdm_mac #(.DW(DW), .CW(CW), .AW(AW), .LANES(LANES)) u_mac (
    .clk(clk), .rst_n(rst_n), .run(run), .last(last), .clr_n(clr_n), .ph(ph),
    .taps(taps), .coefs(coef_data), .xin(xin), .chain_end(chain_end),
    .res(res), .vld(res_vld)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b1;
    else        oe_q <= oe_n;
  end

  assign res_drive = !oe_q;
  assign coef_addr = {bank, ph};
  assign samp_tick = last;

  AST_DRIVE_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (res_drive == !$past(oe_n))); // R9
endmodule

// File: tb/sim_fir_tdm_core.sv
module sim_fir_tdm_core;
  localparam int LANES   = 2;
  localparam int CLR_LEN = 4;
  localparam int NV      = 6;
  // stimulus table: ratio code, samples, bank pattern, chain_end, xin, seed
  localparam int V_RS   [NV] = '{0, 1, 2, 3, 3, 0};
  localparam int V_N    [NV] = '{6, 5, 4, 4, 3, 8};
  localparam int V_BANK [NV] = '{8'h00, 8'h0A, 8'h05, 8'h0F, 8'h02, 8'hA5};
  localparam int V_CHN  [NV] = '{1, 0, 0, 1, 0, 0};
  localparam int V_XIN  [NV] = '{32'h12345678, 1000, -7, 55, 32'h7FFFFFF0, -1};
  localparam int V_SEED [NV] = '{3, 5, 9, 0, 11, 13};

  logic clk, rst_n, fen, clr_n, swap, chain_end, oe_n;
  logic [1:0] ratio_sel;
  logic [15:0] din, dout;
  logic [31:0] xin, res;
  logic [3:0] coef_addr;
  logic [LANES*16-1:0] coef_data;
  logic res_drive, res_vld, samp_tick, busy;

  int tests, fails, hcnt;
  int hist [0:1023];
  bit done;

  fir_tdm_core #(.LANES(LANES), .CLR_LEN(CLR_LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .fen(fen), .clr_n(clr_n),
    .swap(swap), .din(din), .dout(dout), .xin(xin), .chain_end(chain_end),
    .coef_addr(coef_addr), .coef_data(coef_data), .oe_n(oe_n), .res(res),
    .res_drive(res_drive), .res_vld(res_vld), .samp_tick(samp_tick), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int cf(input int b, input int k);
    if (b == 0) return (k + 1) * 311 - 2000;
    if (k == 0) return -32768;
    return 7000 - k * 913;
  endfunction

  // coefficient memory model: word {bank, phase}, lane l holds tap phase*LANES+l (R11)
  always_comb begin
    for (int l = 0; l < LANES; l++)
      coef_data[l*16 +: 16] = 16'(cf(int'(coef_addr[3]), int'(coef_addr[2:0]) * LANES + l));
  end

  function automatic logic [15:0] gen(input int seed, input int i);
    int v;
    if (seed == 0) return 16'h8000;
    v = seed * 7919 + i * 4099 - i * i * 37;
    return v[15:0];
  endfunction

  function automatic logic [31:0] exp_res(input int h, input int b, input int t,
                                          input int xv, input int chn);
    longint acc = 0;
    for (int k = 0; k < t; k++) begin
      if (h - k >= 0) acc += longint'(cf(b, k)) * longint'(hist[h-k]);
    end
    if (chn == 0) acc += longint'(xv);
    return acc[31:0];
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic record_sample();
    hist[hcnt] = int'($signed(din));
    hcnt++;
  endtask

  task automatic do_stream(input int rs, input int n, input int bp, input int chn,
                           input int xv, input int seed);
    int r, t, b;
    logic [31:0] pexp;
    r = 1 << rs;
    t = LANES * r;
    pexp = '0;
    @(negedge clk);
    ratio_sel = 2'(rs);
    chain_end = chn[0];
    xin = 32'(xv);
    din = gen(seed, 0);
    swap = bp[0];
    fen = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      record_sample();
      b = (bp >> i) & 1;
      for (int j = 0; j < r; j++) begin
        @(negedge clk);
        if (j == 0) begin
          if (i > 0) begin
            chk(res_vld == 1'b1, "R3 vld", res_vld, 1);
            chk(res == pexp, "R3/R8 result", res, pexp);
          end
          chk(dout == 16'(hcnt - 1 - t >= 0 ? hist[hcnt-1-t] : 0), "R7 dout", dout,
              hcnt - 1 - t >= 0 ? hist[hcnt-1-t] : 0);
          chk(coef_addr[3] == b[0], "R6 bank", coef_addr[3], b);
          if (r > 1) swap = ~b[0];
        end
        if (j == r - 1) begin
          chk(samp_tick == 1'b1, "R1 tick high", samp_tick, 1);
          if (i + 1 < n) begin
            din = gen(seed, i + 1);
            swap = bp[i+1];
          end else fen = 1'b0;
        end else begin
          chk(samp_tick == 1'b0, "R1 tick low", samp_tick, 0);
        end
        if (j < r - 1) @(posedge clk);
      end
      pexp = exp_res(hcnt - 1, b, t, xv, chn);
    end
    @(posedge clk);
    @(negedge clk);
    chk(res_vld == 1'b1, "R3 last vld", res_vld, 1);
    chk(res == pexp, "R3 last result", res, pexp);
    @(negedge clk);
    chk(res_vld == 1'b0 && samp_tick == 1'b0, "R2 stop", {res_vld, samp_tick}, 0);
  endtask

  initial begin
    done = 1'b0;
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; hcnt = 0;
    rst_n = 1'b0; fen = 1'b0; clr_n = 1'b1; swap = 1'b0; chain_end = 1'b1;
    oe_n = 1'b1; ratio_sel = 2'd0; din = '0; xin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(res == 0 && res_vld == 0, "R10 result", {res_vld, res}, 0);
    chk(busy == 0 && samp_tick == 0, "R10 flags", {busy, samp_tick}, 0);
    chk(dout == 0 && res_drive == 0, "R10 dout/drive", {res_drive, dout}, 0);

    // R9 output enable registered
    oe_n = 1'b0;
    #1 chk(res_drive == 1'b0, "R9 not yet", res_drive, 0);
    @(negedge clk);
    chk(res_drive == 1'b1, "R9 enabled", res_drive, 1);
    oe_n = 1'b1;
    @(negedge clk);
    chk(res_drive == 1'b0, "R9 disabled", res_drive, 0);
    oe_n = 1'b0;

    for (int v = 0; v < NV; v++)
      do_stream(V_RS[v], V_N[v], V_BANK[v], V_CHN[v], V_XIN[v], V_SEED[v]);

    // R4 clear mid-period, R5 no restart while fen held
    @(negedge clk);
    ratio_sel = 2'd1;
    din = 16'h1357;
    fen = 1'b1;
    @(posedge clk);
    record_sample();
    @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    for (int c = 1; c <= CLR_LEN; c++) begin
      chk(busy == 1'b1 && res_vld == 1'b0, "R4 busy", {busy, res_vld}, 2);
      @(negedge clk);
    end
    chk(busy == 1'b0, "R4 busy done", busy, 0);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(samp_tick == 1'b0 && res_vld == 1'b0, "R5 no restart", {samp_tick, res_vld}, 0);
    end
    fen = 1'b0;
    @(negedge clk);
    do_stream(1, 3, 8'h03, 0, 21, 17);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule